// File: doc/BRIEF.md
# Warp Memory Access Coalescer

The block receives one memory instruction from a 32-lane warp: a byte address for each lane, a mask of active lanes and a granularity select. It folds the active lanes into the smallest set of aligned segment transactions, and it issues one transaction for each distinct segment the active lanes touch. Each transaction carries the segment base address and the set of lanes that segment serves. The segment size is either 32 bytes (narrow mode) or 128 bytes (wide mode).

A request arrives over a valid/ready handshake. The block then sends one transaction per cycle while downstream is ready, and it marks the final transaction of the request. It takes no new request until that final transaction has left. A request with no active lanes is consumed at once and produces nothing. The block sits between the lane address generation and the memory request queue. Data return and caching are handled elsewhere.

Top module: `warp_coalescer`

## Requirements
- R1: With `inWide`=0, each transaction's `outBase` equals a lane address with its low 5 bits cleared. Active lanes whose addresses share that 32-byte aligned segment appear in the same transaction.
- R2: With `inWide`=1, each transaction's `outBase` equals a lane address with its low 7 bits cleared. Lanes are grouped by 128-byte aligned segment.
- R3: The number of transactions for a request equals the number of distinct segments touched by its active lanes. Thirty-two consecutive 4-byte words starting at byte 0xA0 give 2 transactions in wide mode and 4 in narrow mode.
- R4: When every active lane falls in a different segment, a full mask gives 32 transactions, and each `outMask` has exactly one bit set.
- R5: Transactions leave in increasing order of the lowest-numbered lane each one serves. Bit i of `outMask` stands for lane i, and lane i's address occupies bits [32*i+31:32*i] of `inAddr`.
- R6: The `outMask` values of one request are pairwise disjoint, and their union equals `inMask`. Addresses of inactive lanes have no effect on any output.
- R7: `outLast` is 1 on the final transaction of a request and 0 on all others. After the final transaction is taken, `outValid` falls and `inReady` rises in the next cycle.
- R8: A request with `inMask`=0 is accepted in the cycle it is presented, produces no transaction, and leaves `inReady` high.
- R9: While `outValid`=1 and `outReady`=0, `outBase`, `outMask` and `outLast` hold their values. `inReady` stays 0 from the acceptance of a non-empty request until its final transaction is taken.
- R10: The first transaction is valid in the cycle after acceptance. With `outReady` held high, one transaction is taken every cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Request present |
| inReady | output | 1 | Block can accept a request |
| inAddr | input | 1024 | Per-lane byte addresses, lane i in bits [32*i+31:32*i] |
| inMask | input | 32 | Active lane mask, bit i for lane i |
| inWide | input | 1 | 1 selects 128-byte segments, 0 selects 32-byte segments |
| outValid | output | 1 | Transaction present |
| outReady | input | 1 | Downstream takes the transaction |
| outBase | output | 32 | Aligned segment base address |
| outMask | output | 32 | Lanes served by this transaction |
| outLast | output | 1 | Final transaction of the request |

## Verification
The assertions check the cycle-level protocol on every cycle. They confirm that the outputs hold during a stall, that no request is accepted while transactions are pending, and that an empty request never raises `outValid`. They also confirm that every emitted mask is non-empty and contains its leading lane, and that the pending set shrinks with each take. Only the bench scenarios can show that the grouping is correct: the transaction count, the base values, the ordering and that the masks add up to the input mask. For this the bench compares against a model built from the lane addresses, across strided, reversed, clustered and random patterns in both modes and with random stalls.

// File: rtl/coal_pkg.sv
package coal_pkg;
  typedef struct packed {
    logic load;
    logic pop;
  } coalStrobe_t;
endpackage

// File: rtl/coal_ctrl.sv
module coal_ctrl
  import coal_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        inValid,
  input  logic        maskAny,
  input  logic        outReady,
  input  logic        lastTx,
  output logic        inReady,
  output logic        outValid,
  output coalStrobe_t strobe
);
  typedef enum logic {ST_IDLE, ST_BUSY} state_t;
  state_t stateQ, stateD;

  assign inReady    = (stateQ == ST_IDLE);
  assign outValid   = (stateQ == ST_BUSY);
  assign strobe.load = inReady && inValid && maskAny;
  assign strobe.pop  = outValid && outReady;

  always_comb begin
    stateD = stateQ;
    case (stateQ)
      ST_IDLE: if (strobe.load) stateD = ST_BUSY;
      ST_BUSY: if (strobe.pop && lastTx) stateD = ST_IDLE;
      default: stateD = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) stateQ <= ST_IDLE;
    else       stateQ <= stateD;
  end

  AST_BUSY_BLOCKS: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> !inReady); // R9
  AST_EMPTY_ACK: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inReady && !maskAny) |=> (!outValid && inReady)); // R8
  AST_FIRST_NEXT: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inReady && maskAny) |=> outValid); // R10
  AST_LAST_ENDS: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && outReady && lastTx) |=> (!outValid && inReady)); // R7
endmodule

// File: rtl/coal_datapath.sv
module coal_datapath
  import coal_pkg::*;
#(
  parameter int LANES       = 32,
  parameter int ADDR_W      = 32,
  parameter int NARROW_LOG2 = 5,
  parameter int WIDE_LOG2   = 7
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  coalStrobe_t             strobe,
  input  logic [LANES*ADDR_W-1:0] inAddr,
  input  logic [LANES-1:0]        inMask,
  input  logic                    inWide,
  output logic [ADDR_W-1:0]       outBase,
  output logic [LANES-1:0]        outMask,
  output logic                    lastTx
);
  localparam int LIDX_W = (LANES > 1) ? $clog2(LANES) : 1;
  localparam logic [ADDR_W-1:0] NARROW_OFF = ADDR_W'((64'd1 << NARROW_LOG2) - 64'd1);
  localparam logic [ADDR_W-1:0] WIDE_OFF   = ADDR_W'((64'd1 << WIDE_LOG2) - 64'd1);

  logic [ADDR_W-1:0] addrQ [LANES];
  logic [ADDR_W-1:0] laneBase [LANES];
  logic [LANES-1:0]  pendQ;
  logic              wideQ;
  logic [LIDX_W-1:0] leadIdx;
  logic [ADDR_W-1:0] leadBase;
  logic [ADDR_W-1:0] offMask;
  logic [LANES-1:0]  hit;

  assign offMask = wideQ ? WIDE_OFF : NARROW_OFF;

  always_comb begin
    leadIdx = '0;
    for (int i = LANES - 1; i >= 0; i--) begin
      if (pendQ[i]) leadIdx = LIDX_W'(i);
    end
  end

  assign leadBase = laneBase[leadIdx];

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign laneBase[g] = addrQ[g] & ~offMask;
    assign hit[g]      = pendQ[g] && (laneBase[g] == leadBase);

    always_ff @(posedge clk) begin
      if (!rstN)            addrQ[g] <= '0;
      else if (strobe.load) addrQ[g] <= inAddr[g*ADDR_W +: ADDR_W];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pendQ <= '0;
      wideQ <= 1'b0;
    end else if (strobe.load) begin
      pendQ <= inMask;
      wideQ <= inWide;
    end else if (strobe.pop) begin
      pendQ <= pendQ & ~hit;
    end
  end

  assign outBase = leadBase;
  assign outMask = hit;
  assign lastTx  = ((pendQ & ~hit) == '0);

  AST_MASK_LEADS: assert property (@(posedge clk) disable iff (!rstN)
    (pendQ != '0) |-> (hit != '0) && hit[leadIdx]); // R5
  AST_POP_SHRINKS: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.pop && !strobe.load) |=> ($countones(pendQ) < $countones($past(pendQ)))); // R6
endmodule

// File: rtl/warp_coalescer.sv
module warp_coalescer
  import coal_pkg::*;
#(
  parameter int LANES       = 32,
  parameter int ADDR_W      = 32,
  parameter int NARROW_LOG2 = 5,
  parameter int WIDE_LOG2   = 7
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    inValid,
  output logic                    inReady,
  input  logic [LANES*ADDR_W-1:0] inAddr,
  input  logic [LANES-1:0]        inMask,
  input  logic                    inWide,
  output logic                    outValid,
  input  logic                    outReady,
  output logic [ADDR_W-1:0]       outBase,
  output logic [LANES-1:0]        outMask,
  output logic                    outLast
);
  coalStrobe_t strobe;
  logic        lastTx;

  coal_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .maskAny  (|inMask),
    .outReady (outReady),
    .lastTx   (lastTx),
    .inReady  (inReady),
    .outValid (outValid),
    .strobe   (strobe)
  );

  coal_datapath #(
    .LANES       (LANES),
    .ADDR_W      (ADDR_W),
    .NARROW_LOG2 (NARROW_LOG2),
    .WIDE_LOG2   (WIDE_LOG2)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .inAddr  (inAddr),
    .inMask  (inMask),
    .inWide  (inWide),
    .outBase (outBase),
    .outMask (outMask),
    .lastTx  (lastTx)
  );

  assign outLast = outValid && lastTx;

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |=> (outValid && $stable(outBase) && $stable(outMask) && $stable(outLast))); // R9
  AST_MASK_NONEMPTY: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> (outMask != '0)); // R6
endmodule

// File: tb/sim_warp_coalescer.sv
module sim_warp_coalescer;
  localparam int CLK_PERIOD = 10;
  localparam int LANES = 32;
  localparam int AW = 32;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic inValid = 1'b0;
  logic inReady;
  logic [LANES*AW-1:0] inAddr = '0;
  logic [LANES-1:0] inMask = '0;
  logic inWide = 1'b0;
  logic outValid;
  logic outReady = 1'b0;
  logic [AW-1:0] outBase;
  logic [LANES-1:0] outMask;
  logic outLast;

  int totalCnt = 0;
  int failCnt = 0;
  int lastCount = 0;

  logic [AW-1:0] addr [LANES];
  logic [AW-1:0] expBase [LANES];
  logic [LANES-1:0] expMask [LANES];
  int expN;

  always #(CLK_PERIOD/2) clk = ~clk;

  warp_coalescer u0 (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inReady(inReady),
    .inAddr(inAddr), .inMask(inMask), .inWide(inWide),
    .outValid(outValid), .outReady(outReady), .outBase(outBase),
    .outMask(outMask), .outLast(outLast)
  );

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    totalCnt++;
    if (!ok) begin
      failCnt++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic void buildExp(input logic [LANES-1:0] m, input bit wide);
    logic [LANES-1:0] rem;
    logic [AW-1:0] off;
    off = wide ? 32'h7F : 32'h1F;
    rem = m;
    expN = 0;
    while (rem != '0) begin
      int lead;
      logic [AW-1:0] b;
      logic [LANES-1:0] grp;
      lead = 0;
      for (int i = LANES - 1; i >= 0; i--) if (rem[i]) lead = i;
      b = addr[lead] & ~off;
      grp = '0;
      for (int i = 0; i < LANES; i++) if (rem[i] && ((addr[i] & ~off) == b)) grp[i] = 1'b1;
      expBase[expN] = b;
      expMask[expN] = grp;
      expN++;
      rem = rem & ~grp;
    end
  endfunction

  task automatic runReq(input logic [LANES-1:0] m, input bit wide, input int stallPct, input string tag);
    int idx;
    int cycles;
    bit prevStall;
    logic [AW-1:0] hb;
    logic [LANES-1:0] hm;
    logic hl;
    logic [LANES-1:0] uni;
    buildExp(m, wide);
    @(negedge clk);
    for (int i = 0; i < LANES; i++) inAddr[i*AW +: AW] = addr[i];
    inMask = m;
    inWide = wide;
    inValid = 1'b1;
    check(inReady === 1'b1, {tag, " R9 ready when idle"}, 64'(inReady), 1);
    @(negedge clk);
    inValid = 1'b0;
    for (int i = 0; i < LANES; i++) inAddr[i*AW +: AW] = $urandom;
    if (expN == 0) begin
      check(outValid === 1'b0, {tag, " R8 no transaction"}, 64'(outValid), 0);
      check(inReady === 1'b1, {tag, " R8 ready stays"}, 64'(inReady), 1);
      lastCount = 0;
      return;
    end
    check(outValid === 1'b1, {tag, " R10 valid next cycle"}, 64'(outValid), 1);
    idx = 0;
    cycles = 0;
    prevStall = 1'b0;
    hb = '0; hm = '0; hl = 1'b0;
    uni = '0;
    while (idx < expN && cycles < 2000) begin
      bit rdy;
      rdy = ($urandom % 100) >= stallPct;
      outReady = rdy;
      cycles++;
      check(outValid === 1'b1 && inReady === 1'b0, {tag, " R9 busy handshake"},
            {outValid, inReady}, 2'b10);
      if (prevStall)
        check(outBase === hb && outMask === hm && outLast === hl, {tag, " R9 stall hold"},
              {outBase, outMask}, {hb, hm});
      if (rdy) begin
        check(outBase === expBase[idx], {tag, " R1 R2 R5 base"}, 64'(outBase), 64'(expBase[idx]));
        check(outMask === expMask[idx], {tag, " R5 R6 mask"}, 64'(outMask), 64'(expMask[idx]));
        check(outLast === (idx == expN - 1), {tag, " R7 last flag"}, 64'(outLast), 64'(idx == expN - 1));
        check((uni & outMask) == '0, {tag, " R6 disjoint"}, 64'(uni & outMask), 0);
        uni = uni | outMask;
        idx++;
        prevStall = 1'b0;
      end else begin
        prevStall = 1'b1;
        hb = outBase; hm = outMask; hl = outLast;
      end
      @(negedge clk);
    end
    outReady = 1'b0;
    check(uni === m, {tag, " R6 union"}, 64'(uni), 64'(m));
    check(outValid === 1'b0 && inReady === 1'b1, {tag, " R7 done"}, {outValid, inReady}, 2'b01);
    if (stallPct == 0) check(cycles == expN, {tag, " R10 one per cycle"}, 64'(cycles), 64'(expN));
    lastCount = idx;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failCnt++;
    totalCnt++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", totalCnt - failCnt, totalCnt);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(outValid === 1'b0 && inReady === 1'b1, "R7 reset state", {outValid, inReady}, 2'b01);
    rstN = 1'b1;
    @(negedge clk);
    check(outValid === 1'b0 && inReady === 1'b1, "R8 idle after reset", {outValid, inReady}, 2'b01);

    // R3: consecutive words from 0xA0
    for (int i = 0; i < LANES; i++) addr[i] = 32'hA0 + 4 * i;
    runReq('1, 1'b1, 0, "R3 wide words");
    check(lastCount == 2, "R3 wide count", 64'(lastCount), 2);
    runReq('1, 1'b0, 0, "R3 narrow words");
    check(lastCount == 4, "R3 narrow count", 64'(lastCount), 4);

    // R4: each lane in its own segment
    for (int i = 0; i < LANES; i++) addr[i] = 32'h4000 + 128 * i;
    runReq('1, 1'b1, 0, "R4 stride128");
    check(lastCount == 32, "R4 wide worst count", 64'(lastCount), 32);
    for (int i = 0; i < LANES; i++) addr[i] = 32'h8000 + 32 * i + 3;
    runReq('1, 1'b0, 30, "R4 stride32");
    check(lastCount == 32, "R4 narrow worst count", 64'(lastCount), 32);

    // R5: reversed addresses, ordering by lowest lane
    for (int i = 0; i < LANES; i++) addr[i] = 32'h200 + 4 * (31 - i);
    runReq('1, 1'b0, 0, "R5 reversed");
    check(lastCount == 4, "R5 reversed count", 64'(lastCount), 4);

    // R1/R2: single segment
    for (int i = 0; i < LANES; i++) addr[i] = 32'h1000 + (i % 8);
    runReq('1, 1'b0, 0, "R1 same segment");
    check(lastCount == 1, "R1 one transaction", 64'(lastCount), 1);

    // R8: empty mask
    runReq('0, 1'b1, 0, "R8 empty");

    // R6: inactive lanes carry scattered addresses
    for (int i = 0; i < LANES; i++) addr[i] = (i % 2 == 0) ? 32'h300 + i : 32'h9000_0000 + 256 * i;
    runReq(32'h5555_5555, 1'b1, 0, "R6 inactive ignored");
    check(lastCount == 1, "R6 inactive count", 64'(lastCount), 1);

    // random sweep: clustered addresses, both modes, stalls
    for (int r = 0; r < 300; r++) begin
      logic [AW-1:0] region;
      region = $urandom & 32'hFFFF_F000;
      for (int i = 0; i < LANES; i++) addr[i] = region + ($urandom % (r % 3 == 0 ? 512 : 4096));
      runReq((r % 7 == 0) ? LANES'(32'h1 << (r % 32)) : LANES'($urandom), r[0], (r % 4) * 15, "R2 R3 sweep");
    end

    $display("%0d/%0d checks passed", totalCnt - failCnt, totalCnt);
    $finish;
  end
endmodule